// File: doc/BRIEF.md
# RTC Periodic Rate Divider

This block sits behind the control registers of a real-time clock. It counts a 32.768 kHz time-base enable and produces two outputs. The first is a one-cycle pulse that sets the periodic flag each time a programmed period completes. The second is a square-wave level at the same rate. A 4-bit rate code picks the period and a 3-bit oscillator code decides whether the chain counts at all. A separate enable gates the square wave onto its pin.

Software writes the rate and oscillator codes together through one write strobe. Every such write restarts the period from the new setting. The square-wave enable has a strobe of its own and does not disturb the count. The rate and oscillator codes hold their values through reset. The square-wave enable is cleared by reset.

Top module: `rtc_rate_div`

## Requirements
- R1: While reset is asserted, and right after it, per_tick_o and sq_wave_o are low. Reset clears the square-wave enable, so sq_wave_o stays low until sq_en_i = 1 is written, while per_tick_o keeps running.
- R2: For a rate code of 3 to 15, per_tick_o pulses once every 2^(code-1) time-base ticks. Each pulse is exactly one clock wide and comes in the cycle after the clock edge that samples the expiring tick.
- R3: For a rate code of 1 or 2, the period is 2^(code+6) time-base ticks, so code 1 gives 128 ticks and code 2 gives 256 ticks.
- R4: Rate code 0 disables the output: per_tick_o never pulses and sq_wave_o stays low.
- R5: Only oscillator code 3'b010 lets the chain count. With any other code, per_tick_o never pulses and sq_wave_o stays low. When the code returns to 3'b010, a full new period starts.
- R6: With the enable set, sq_wave_o is low for the first half of each period after a restart and high for the second half. It falls in the same cycle that per_tick_o pulses.
- R7: With the enable clear, sq_wave_o is held low while per_tick_o continues at the selected rate. Writing the enable does not restart the period.
- R8: Any write through rate_we_i reloads the counter, so the next pulse comes one full period of the written rate after the write, even when the value written is unchanged.
- R9: The rate and oscillator codes survive reset. After reset is released, a full period of the retained rate runs without any rewrite.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | Time-base enable, one cycle per 32.768 kHz period |
| rate_we_i | input | 1 | Write strobe for rate and oscillator codes |
| rate_sel_i | input | 4 | Rate code written on rate_we_i |
| osc_ctl_i | input | 3 | Oscillator code written on rate_we_i |
| sq_en_we_i | input | 1 | Write strobe for the square-wave enable |
| sq_en_i | input | 1 | Square-wave enable written on sq_en_we_i |
| per_tick_o | output | 1 | Periodic-flag set pulse |
| sq_wave_o | output | 1 | Square-wave level |

## Verification
If the down-counter starts from the wrong value or decrements at the wrong time, the pulse on per_tick_o is misplaced on the first period after a restart, at most 2^14 ticks later. A wrong half-period compare shows up as a square-wave edge at the wrong tick inside that same first period. A missed reload after a write, or a restart taken on a non-running oscillator code, shows up as a pulse placed relative to the old period rather than the write.

// File: rtl/rtc_rate_pkg.sv
package rtc_rate_pkg;
  localparam int unsigned RS_W    = 4;
  localparam int unsigned DV_W    = 3;
  localparam int unsigned MAX_EXP = 14;
  localparam int unsigned EXP_W   = $clog2(MAX_EXP + 1);
  localparam logic [DV_W-1:0] DV_RUN = 3'b010;

  // log2 of the period in time-base ticks; codes 1 and 2 alias to slow taps
  function automatic logic [EXP_W-1:0] rate_exp(input logic [RS_W-1:0] rs);
    logic [EXP_W-1:0] e;
    if (rs == '0)                  e = '0;
    else if (rs < RS_W'(3))        e = EXP_W'(rs) + EXP_W'(6);
    else                           e = EXP_W'(rs) - EXP_W'(1);
    return e;
  endfunction
endpackage

// File: rtl/rtc_rate_ctl.sv
module rtc_rate_ctl
  import rtc_rate_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            rate_we_i,
  input  logic [RS_W-1:0] rate_sel_i,
  input  logic [DV_W-1:0] osc_ctl_i,
  input  logic            sq_en_we_i,
  input  logic            sq_en_i,
  output logic [RS_W-1:0] rate_sel_o,
  output logic [DV_W-1:0] osc_ctl_o,
  output logic            sq_en_o,
  output logic            reload_o
);
  logic [RS_W-1:0] rs_q;
  logic [DV_W-1:0] dv_q;
  logic            sqe_q, reload_q, init_q;

  // rate and oscillator codes deliberately keep their value across reset
  always_ff @(posedge clk_i) begin
    if (rate_we_i) begin
      rs_q <= rate_sel_i;
      dv_q <= osc_ctl_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sqe_q    <= 1'b0;
      reload_q <= 1'b0;
      init_q   <= 1'b1;
    end else begin
      init_q   <= 1'b0;
      reload_q <= rate_we_i;
      if (sq_en_we_i) sqe_q <= sq_en_i;
    end
  end

  assign rate_sel_o = rs_q;
  assign osc_ctl_o  = dv_q;
  assign sq_en_o    = sqe_q;
  assign reload_o   = reload_q | init_q;
endmodule

// File: rtl/rtc_rate_cnt.sv
module rtc_rate_cnt
  import rtc_rate_pkg::*;
#(
  parameter int unsigned CNT_W = MAX_EXP + 1
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            tick_i,
  input  logic            reload_i,
  input  logic [RS_W-1:0] rate_sel_i,
  input  logic [DV_W-1:0] osc_ctl_i,
  output logic            restart_o,
  output logic            wrap_o,
  output logic            half_o,
  output logic            pulse_o
);
  logic [CNT_W-1:0] cnt_q, period, half;
  logic             active, pulse_q;

  assign period    = CNT_W'(1) << rate_exp(rate_sel_i);
  assign half      = period >> 1;
  assign active    = (osc_ctl_i == DV_RUN) && (rate_sel_i != '0);
  assign restart_o = reload_i || !active;
  assign wrap_o    = !restart_o && tick_i && (cnt_q == CNT_W'(1));
  assign half_o    = !restart_o && tick_i && (cnt_q == half + CNT_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      pulse_q <= 1'b0;
    end else begin
      pulse_q <= wrap_o;
      if (restart_o)   cnt_q <= period;
      else if (wrap_o) cnt_q <= period;
      else if (tick_i) cnt_q <= cnt_q - CNT_W'(1);
    end
  end

  assign pulse_o = pulse_q;
endmodule

// File: rtl/rtc_rate_sqw.sv
module rtc_rate_sqw (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic restart_i,
  input  logic wrap_i,
  input  logic half_i,
  input  logic en_i,
  output logic wave_o
);
  logic phase_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                phase_q <= 1'b0;
    else if (restart_i || wrap_i) phase_q <= 1'b0;
    else if (half_i)            phase_q <= 1'b1;
  end

  assign wave_o = en_i & phase_q;
endmodule

// File: rtl/rtc_rate_div.sv
module rtc_rate_div
  import rtc_rate_pkg::*;
#(
  parameter int unsigned CNT_W = MAX_EXP + 1
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            tick_i,
  input  logic            rate_we_i,
  input  logic [RS_W-1:0] rate_sel_i,
  input  logic [DV_W-1:0] osc_ctl_i,
  input  logic            sq_en_we_i,
  input  logic            sq_en_i,
  output logic            per_tick_o,
  output logic            sq_wave_o
);
  logic [RS_W-1:0] rs_q;
  logic [DV_W-1:0] dv_q;
  logic            sqe_q, reload, restart, wrap, half;

  rtc_rate_ctl u_ctl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .rate_we_i  (rate_we_i),
    .rate_sel_i (rate_sel_i),
    .osc_ctl_i  (osc_ctl_i),
    .sq_en_we_i (sq_en_we_i),
    .sq_en_i    (sq_en_i),
    .rate_sel_o (rs_q),
    .osc_ctl_o  (dv_q),
    .sq_en_o    (sqe_q),
    .reload_o   (reload)
  );

  rtc_rate_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .tick_i     (tick_i),
    .reload_i   (reload),
    .rate_sel_i (rs_q),
    .osc_ctl_i  (dv_q),
    .restart_o  (restart),
    .wrap_o     (wrap),
    .half_o     (half),
    .pulse_o    (per_tick_o)
  );

  rtc_rate_sqw u_sqw (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .restart_i (restart),
    .wrap_i    (wrap),
    .half_i    (half),
    .en_i      (sqe_q),
    .wave_o    (sq_wave_o)
  );
endmodule

// File: rtl/rtc_rate_div_chk.sv
module rtc_rate_div_chk
  import rtc_rate_pkg::*;
(
  input logic            clk_i,
  input logic            rst_ni,
  input logic            tick_i,
  input logic            sq_en_we_i,
  input logic            per_tick_o,
  input logic            sq_wave_o,
  input logic [RS_W-1:0] rs_q,
  input logic [DV_W-1:0] dv_q,
  input logic            restart
);
  assert_pulse_one_cycle_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    per_tick_o |=> !per_tick_o);

  assert_pulse_needs_tick_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    per_tick_o |-> $past(tick_i));

  // covers R4 as well: no pulse without a running chain and nonzero rate
  assert_pulse_needs_run_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    per_tick_o |-> $past((dv_q == DV_RUN) && (rs_q != '0)));

  assert_wave_low_at_pulse_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    per_tick_o |-> !sq_wave_o);

  assert_wave_change_cause_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(sq_wave_o) |-> ($past(tick_i) || $past(sq_en_we_i) || $past(restart)));
endmodule

bind rtc_rate_div rtc_rate_div_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .tick_i     (tick_i),
  .sq_en_we_i (sq_en_we_i),
  .per_tick_o (per_tick_o),
  .sq_wave_o  (sq_wave_o),
  .rs_q       (rs_q),
  .dv_q       (dv_q),
  .restart    (restart)
);

// File: tb/rtc_rate_div_tb_top.sv
module rtc_rate_div_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0;
  logic       rate_we = 1'b0;
  logic [3:0] rate_sel = '0;
  logic [2:0] osc_ctl = '0;
  logic       sq_en_we = 1'b0;
  logic       sq_en = 1'b0;
  logic       per_tick, sq_wave;

  int  vectors = 0;
  int  fails = 0;
  bit  done = 0;
  // bench-side model
  int  k = 0;
  int  rs_m = 0;
  int  dv_m = 0;
  bit  sqe_m = 0;

  always #2 clk = ~clk;

  rtc_rate_div dut_i (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .tick_i     (tick),
    .rate_we_i  (rate_we),
    .rate_sel_i (rate_sel),
    .osc_ctl_i  (osc_ctl),
    .sq_en_we_i (sq_en_we),
    .sq_en_i    (sq_en),
    .per_tick_o (per_tick),
    .sq_wave_o  (sq_wave)
  );

  function automatic int period_of(int rs);
    if (rs < 3) return 1 << (rs + 6);
    return 1 << (rs - 1);
  endfunction

  task automatic check(bit ok, string tag, int act, int exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s k=%0d rs=%0d dv=%0d act=%0d exp=%0d", tag, k, rs_m, dv_m, act, exp);
    end
  endtask

  task automatic wr_rate(int rs, int dv);
    @(negedge clk);
    rate_we = 1'b1; rate_sel = 4'(rs); osc_ctl = 3'(dv);
    @(negedge clk);
    rate_we = 1'b0;
    @(negedge clk);
    rs_m = rs; dv_m = dv; k = 0;
  endtask

  task automatic wr_en(bit v);
    @(negedge clk);
    sq_en_we = 1'b1; sq_en = v;
    @(negedge clk);
    sq_en_we = 1'b0;
    sqe_m = v;
  endtask

  task automatic run_ticks(int n, string tag);
    for (int i = 0; i < n; i++) begin
      bit act, pf_e, ph;
      int p;
      @(negedge clk); tick = 1'b1;
      @(negedge clk); tick = 1'b0;
      act = (dv_m == 2) && (rs_m != 0);
      p = period_of(rs_m);
      k++;
      pf_e = act && ((k % p) == 0);
      ph   = act && ((k % p) >= p / 2);
      check(per_tick == pf_e, {tag, " pulse"}, int'(per_tick), int'(pf_e));
      check(sq_wave == (sqe_m & ph), {tag, " wave"}, int'(sq_wave), int'(sqe_m & ph));
      @(negedge clk);
      check(per_tick == 1'b0, "R2 pulse width", int'(per_tick), 0);
      check(sq_wave == (sqe_m & ph), {tag, " wave hold"}, int'(sq_wave), int'(sqe_m & ph));
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(per_tick == 1'b0, "R1 reset pulse", int'(per_tick), 0);
    check(sq_wave == 1'b0, "R1 reset wave", int'(sq_wave), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(per_tick == 1'b0 && sq_wave == 1'b0, "R1 after reset", int'({per_tick, sq_wave}), 0);

    wr_en(1'b1);
    // rate sweep with running oscillator
    for (int rs = 1; rs < 16; rs++) begin
      int p = period_of(rs);
      wr_rate(rs, 2);
      run_ticks(p + p / 2 + 2, rs < 3 ? "R3 slow alias" : "R2 rate R6");
    end

    // R4: rate code 0
    wr_rate(0, 2);
    run_ticks(64, "R4 rate zero");

    // R5: every non-running oscillator code, then restart
    for (int dv = 0; dv < 8; dv++) begin
      if (dv == 2) continue;
      wr_rate(3, dv);
      run_ticks(16, "R5 stopped");
      wr_rate(3, 2);
      run_ticks(6, "R5 restart");
    end

    // R7: enable clear keeps wave low, pulses continue, no restart
    wr_rate(4, 2);
    run_ticks(5, "R7 pre");
    wr_en(1'b0);
    run_ticks(12, "R7 wave off");
    wr_en(1'b1);
    run_ticks(10, "R7 wave on");

    // R8: rewrite of the same value restarts the period
    wr_rate(5, 2);
    run_ticks(10, "R8 pre");
    wr_rate(5, 2);
    run_ticks(20, "R8 reload");

    // R9 and R1: reset mid-period keeps codes, clears enable
    wr_rate(4, 2);
    run_ticks(3, "R9 pre");
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk);
    check(per_tick == 1'b0 && sq_wave == 1'b0, "R1 mid reset", int'({per_tick, sq_wave}), 0);
    rst_n = 1'b1; k = 0; sqe_m = 0;
    @(negedge clk);
    run_ticks(20, "R9 retained R1 enable cleared");
    wr_en(1'b1);
    run_ticks(10, "R1 enable rewritten");

    finish_run();
  end

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired act=%0d exp=%0d", vectors, 0);
    finish_run();
  end
endmodule